// File: doc/BRIEF.md
# Redundant-Digit Combiner for a 1.5-Bit-Per-Stage Pipelined Converter

This block is the digital back end of a pipelined analog-to-digital converter made of cascaded 1.5-bit stages. Every stage has two comparators with trip points at a quarter of full scale on either side of zero. The stage reports which of three regions its input fell in, and that region stands for a signed digit of -1, 0 or +1. The first stage gives the most significant digit. Each later stage works on the amplified residue of the stage before it, one clock later, so the digits that belong to one sample arrive skewed in time.

The combiner decodes each stage's comparator pair into a digit. It delays each stage's digit so that all digits of one sample meet in the same cycle. It then adds them with binary weights, 2^(N-1) for the first stage down to 1 for the last, and registers a signed result with a valid flag. The block takes a new sample on every clock. A valid strobe travels with the first stage's digit, so gaps in the input stream come out as gaps in the output after the same latency. A sticky flag records any comparator pair that shows the impossible code.

Top module: `pdc_combiner`

## Requirements
- R1: Stage i drives `cmp[2i+1:2i]`. The code 2'b00 stands for digit -1, 2'b01 for digit 0 and 2'b11 for digit +1.
- R2: Stage i (0-based, stage 0 first) carries the weight 2^(N-1-i). The output is the sum of the digits times their weights.
- R3: The codes of one sample are presented skewed. Stage 0 comes in the cycle where `in_valid` is high, and stage i comes i cycles later. The block combines exactly these codes into one result.
- R4: If a sample's `in_valid` is captured at clock edge k, its result and `out_valid` appear after clock edge k+N-1, which is N rising edges counting edge k.
- R5: Samples on consecutive cycles are all accepted. A burst of back-to-back valid inputs gives a burst of back-to-back valid outputs.
- R6: A cycle with `in_valid` low gives a cycle with `out_valid` low after the same latency as a valid sample.
- R7: While `out_valid` is low, `out_word` keeps the last valid result.
- R8: `out_word` is signed, N+1 bits wide, and spans -(2^N-1) to +(2^N-1). For N=7, the digits +1,0,+1,0,-1,0,+1 give 77, all +1 give 127 and all -1 give -127.
- R9: The code 2'b10 on a stage that is carrying a valid sample counts as digit 0 and sets `code_err`. Once set, `code_err` stays high until reset. The same code on a stage that is carrying a bubble has no effect.
- R10: The reset is synchronous and active low. It clears `out_valid`, `out_word`, `code_err` and every delay register. After reset, `out_valid` rises only for samples that entered after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Marks a new sample at stage 0 in this cycle |
| cmp | input | 2*N | Comparator pairs; stage i on bits 2i+1:2i |
| out_valid | output | 1 | `out_word` holds a newly combined sample |
| out_word | output | N+1 | Signed combined result |
| code_err | output | 1 | Sticky flag for an illegal comparator code on a valid sample |

## Verification
The bench first drives the three extreme digit patterns: the mixed-sign example, all plus and all minus. A wrong weight or a wrong sign extension would move these results away from 77, 127 and -127. Random bursts mixed with bubbles catch two faults. A delay that is one cycle wrong on any stage would combine digits from neighbouring samples. A valid strobe that is delayed differently from the digits would shift or drop the bubbles. An illegal code is placed in a bubble, where it must be ignored, and in a valid sample, where it must count as zero and latch the flag. A later reset must clear that flag, which catches a design that never sets it, one that sets it on bubbles, and one that forgets to clear it.

// File: rtl/pdc_pkg.sv
// Shared types and code values for the pipelined-converter digit combiner.
// Assumes a comparator pair is reported as a 2-bit thermometer code.
package pdc_pkg;
    typedef logic signed [1:0] digit_t;

    localparam logic [1:0] CODE_NEG  = 2'b00;
    localparam logic [1:0] CODE_ZERO = 2'b01;
    localparam logic [1:0] CODE_POS  = 2'b11;
    localparam logic [1:0] CODE_BAD  = 2'b10;
endpackage

// File: rtl/pdc_stage_decode.sv
// Turns one stage's comparator pair into a signed digit.
// Assumes thermometer coding. The impossible code yields digit 0 and is flagged.
module pdc_stage_decode
    import pdc_pkg::*;
(
    input  logic [1:0] code,
    output digit_t     digit,
    output logic       illegal
);
    // Map the three legal regions to -1/0/+1 and flag the fourth code.
    always_comb begin
        illegal = 1'b0;
        case (code)
            CODE_NEG:  digit = -2'sd1;
            CODE_POS:  digit = 2'sd1;
            CODE_ZERO: digit = 2'sd0;
            default: begin
                digit   = 2'sd0;
                illegal = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/pdc_delay_line.sv
// Fixed-length register delay for one stage's digit.
// A DEPTH of zero gives a plain wire. The reset clears every tap.
module pdc_delay_line #(
    parameter int WIDTH = 2,
    parameter int DEPTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    generate
        if (DEPTH == 0) begin : g_wire
            assign dout = din;
        end else begin : g_regs
            logic [WIDTH-1:0] tap_q [DEPTH];

            // Shift the digit one tap per clock and clear it on reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int j = 0; j < DEPTH; j++) tap_q[j] <= '0;
                end else begin
                    tap_q[0] <= din;
                    for (int j = 1; j < DEPTH; j++) tap_q[j] <= tap_q[j-1];
                end
            end

            assign dout = tap_q[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/pdc_weighted_sum.sv
// Adds aligned digits with binary weights and registers the result.
// Assumes digit i sits at bits 2i+1:2i and carries weight 2^(N-1-i).
// The result loads only when load_en is high and holds otherwise.
module pdc_weighted_sum #(
    parameter int N = 7,
    parameter int W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2*N-1:0]      digits,
    input  logic                load_en,
    output logic                sum_valid,
    output logic signed [W-1:0] sum_q
);
    logic signed [W-1:0] sum_d;

    // Sign-extend each digit, shift it to its weight and accumulate.
    always_comb begin
        logic signed [W-1:0] term;
        sum_d = '0;
        for (int i = 0; i < N; i++) begin
            term  = W'($signed(digits[2*i +: 2]));
            term  = term <<< (N - 1 - i);
            sum_d = sum_d + term;
        end
    end

    // Register the sum for a valid sample; keep the old word for bubbles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_valid <= 1'b0;
            sum_q     <= '0;
        end else begin
            sum_valid <= load_en;
            if (load_en) sum_q <= sum_d;
        end
    end
endmodule

// File: rtl/pdc_combiner.sv
// Top of the digit combiner. It decodes N comparator pairs, aligns the skewed
// digits with per-stage delays of N-1-i cycles and sums them with binary weights.
// Assumes stage i presents a sample's code i cycles after stage 0. The valid
// strobe comes with stage 0. N must be at least 2.
module pdc_combiner
    import pdc_pkg::*;
#(
    parameter int N = 7,
    localparam int W = $clog2((1 << N) - 1) + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [2*N-1:0]      cmp,
    output logic                out_valid,
    output logic signed [W-1:0] out_word,
    output logic                code_err
);
    logic [N-1:0]   stage_live;   // stage i currently holds a valid sample
    logic [N-1:0]   stage_bad;
    logic [2*N-1:0] aligned;
    logic [N-1:1]   vtap_q;
    logic           err_hit;

    // Carry the valid strobe down the stages, one tap per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) vtap_q <= '0;
        else        vtap_q <= {vtap_q[N-2:1], in_valid};
    end

    assign stage_live = {vtap_q, in_valid};

    generate
        for (genvar i = 0; i < N; i++) begin : g_stage
            digit_t dig;

            pdc_stage_decode u_dec (
                .code    (cmp[2*i +: 2]),
                .digit   (dig),
                .illegal (stage_bad[i])
            );

            pdc_delay_line #(
                .WIDTH (2),
                .DEPTH (N - 1 - i)
            ) u_dly (
                .clk   (clk),
                .rst_n (rst_n),
                .din   (dig),
                .dout  (aligned[2*i +: 2])
            );
        end
    endgenerate

    assign err_hit = |(stage_live & stage_bad);

    // Latch the error flag on an illegal code that belongs to a live sample.
    always_ff @(posedge clk) begin
        if (!rst_n)       code_err <= 1'b0;
        else if (err_hit) code_err <= 1'b1;
    end

    pdc_weighted_sum #(
        .N (N),
        .W (W)
    ) u_sum (
        .clk       (clk),
        .rst_n     (rst_n),
        .digits    (aligned),
        .load_en   (stage_live[N-1]),
        .sum_valid (out_valid),
        .sum_q     (out_word)
    );
endmodule

// File: rtl/pdc_checker.sv
// Assertion checker for pdc_combiner, attached with bind.
// It watches only ports and keeps its own counters.
module pdc_checker #(
    parameter int N = 7,
    parameter int W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic                out_valid,
    input logic signed [W-1:0] out_word,
    input logic                code_err
);
    localparam int CW = $clog2(N + 2) + 1;
    localparam logic signed [W-1:0] FULL = W'((1 << N) - 1);

    logic [CW-1:0] since_rst;
    logic [CW-1:0] inflight;

    // Count the clocks since reset, saturating above N.
    always_ff @(posedge clk) begin
        if (!rst_n)                 since_rst <= '0;
        else if (since_rst <= CW'(N)) since_rst <= since_rst + 1'b1;
    end

    // Track samples that were accepted but have not yet come out.
    always_ff @(posedge clk) begin
        if (!rst_n) inflight <= '0;
        else        inflight <= inflight + CW'(in_valid) - CW'(out_valid);
    end

    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        code_err |=> code_err);

    a_r10_no_early_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> since_rst >= CW'(N));

    a_r8_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_word <= FULL && out_word >= -FULL));

    a_r7_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_word));

    a_r6_inflight_bound: assert property (@(posedge clk) disable iff (!rst_n)
        inflight <= CW'(N));

    a_r4_no_orphan_out: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> inflight != '0);
endmodule

bind pdc_combiner pdc_checker #(.N(N), .W(W)) u_pdc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_word  (out_word),
    .code_err  (code_err)
);

// File: tb/tb_pdc_combiner.sv
`timescale 1ns/1ps
// Self-checking bench: a behavioural model built from per-sample digit arrays
// drives the skewed comparator codes and predicts every output cycle.
module tb_pdc_combiner;
    localparam int N  = 7;
    localparam int W  = N + 1;
    localparam int NS = 120;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                in_valid = 1'b0;
    logic [2*N-1:0]      cmp = '0;
    logic                out_valid;
    logic signed [W-1:0] out_word;
    logic                code_err;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;

    int  dig [NS][N];
    bit  vld [NS];
    bit  ill [NS][N];

    always #2.5 clk = ~clk;

    pdc_combiner #(.N(N)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .cmp       (cmp),
        .out_valid (out_valid),
        .out_word  (out_word),
        .code_err  (code_err)
    );

    function automatic logic [1:0] enc(input int d);
        if (d < 0)  return 2'b00;
        if (d == 0) return 2'b01;
        return 2'b11;
    endfunction

    function automatic int ref_sum(input int s);
        int acc = 0;
        for (int i = 0; i < N; i++)
            if (!ill[s][i]) acc += dig[s][i] * (1 << (N - 1 - i));
        return acc;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Build one run of samples: fixed corner patterns, random bursts and bubbles.
    task automatic gen(input int run);
        for (int s = 0; s < NS; s++) begin
            vld[s] = ($urandom_range(3) != 0);
            if (s >= 50 && s < 80) vld[s] = 1;           // R5 back-to-back burst
            if (s >= NS - N - 2)   vld[s] = 0;           // drain
            for (int i = 0; i < N; i++) begin
                dig[s][i] = int'($urandom_range(2)) - 1;
                ill[s][i] = !vld[s] && ($urandom_range(3) == 0);  // R9 ignored in bubbles
            end
        end
        for (int s = 0; s < 3; s++) vld[s] = 1;
        dig[0] = '{1, 0, 1, 0, -1, 0, 1};                // R8 example -> 77
        for (int i = 0; i < N; i++) begin
            dig[1][i] = 1;
            dig[2][i] = -1;
            ill[0][i] = 0; ill[1][i] = 0; ill[2][i] = 0;
        end
        if (run == 0) begin
            vld[40] = 1;
            for (int i = 0; i < N; i++) ill[40][i] = 0;
            ill[40][3] = 1;                              // R9 counted as zero
            ill[40][6] = 1;
        end
    endtask

    task automatic do_reset();
        rst_n    = 1'b0;
        in_valid = 1'b0;
        cmp      = {N{2'b10}};
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R10 out_valid in reset", out_valid, 0);
        chk(out_word == '0, "R10 out_word in reset", int'(out_word), 0);
        chk(code_err == 1'b0, "R10 code_err in reset", code_err, 0);
        rst_n = 1'b1;
    endtask

    // Drive skewed codes and compare the outputs on every cycle.
    task automatic stream();
        int  exp_word = 0;
        bit  err_exp = 0;
        for (int c = 0; c < NS + N; c++) begin
            @(negedge clk);
            if (c > 0) begin
                int s = c - N;
                bit ev = (s >= 0) && (s < NS) && vld[s];
                if (ev) exp_word = ref_sum(s);
                chk(out_valid == ev, "R3 R4 R5 R6 R10 out_valid", out_valid, ev);
                chk(int'(out_word) == exp_word, "R1 R2 R3 R7 out_word",
                    int'(out_word), exp_word);
                chk(code_err == err_exp, "R9 code_err", code_err, err_exp);
                if (ev && s == 0) chk(int'(out_word) == 77, "R8 example", int'(out_word), 77);
                if (ev && s == 1) chk(int'(out_word) == 127, "R8 plus full scale", int'(out_word), 127);
                if (ev && s == 2) chk(int'(out_word) == -127, "R8 minus full scale", int'(out_word), -127);
            end
            in_valid = (c < NS) ? vld[c] : 1'b0;
            for (int i = 0; i < N; i++) begin
                int s2 = c - i;
                if (s2 >= 0 && s2 < NS) begin
                    cmp[2*i +: 2] = ill[s2][i] ? 2'b10 : enc(dig[s2][i]);
                    if (vld[s2] && ill[s2][i]) err_exp = 1;
                end else begin
                    cmp[2*i +: 2] = 2'b01;
                end
            end
        end
    endtask

    initial begin
        do_reset();
        gen(0);
        stream();
        do_reset();
        gen(1);
        stream();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule